// File: doc/BRIEF.md
# Repeating Loop Code Generator

This block sends a serial line stream made of a short user pattern repeated back to back. It is used to put a loop-up or loop-down request on a line toward remote equipment. Software writes two 8-bit code bytes, a length select and an enable through a small write-only register port. The block then emits one bit each time the line clock enable pulses. While the block is enabled, the pattern repeats with no gaps. When it is disabled, the normal transmit data bit passes through instead.

The length select gives a period of 5, 6, 7 or 16 bits. The 16-bit period carries lengths 1, 2, 4 and 8 when the code is written repeatedly across both bytes. The 6-bit period carries length 3 in the same way. Bits leave MSB first: first the top of code byte 0, then code byte 1 when the period is 16. New codes or a new length are picked up only when a pattern starts, so a write can never cut a pattern short.

Top module: `loopgen_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tx_bit` becomes 0 and the generator is disabled; both code bytes and the length select clear to 0.
- R2: While disabled, each clock with `line_ce` high loads `tx_data` into `tx_bit`, which is visible after that edge. Clearing the enable returns the output to `tx_data` at the next `line_ce`.
- R3: `tx_bit` changes only on clock edges where `line_ce` is high or reset is applied.
- R4: Length select 00 gives a 5-bit period made of bits 7..3 of code byte 0, MSB first. For example, 80h gives 10000 repeated.
- R5: Length select 01 gives a 6-bit period made of bits 7..2 of code byte 0, MSB first.
- R6: Length select 10 gives a 7-bit period made of bits 7..1 of code byte 0, MSB first.
- R7: Length select 11 gives a 16-bit period: code byte 0 bits 7..0, then code byte 1 bits 7..0. Replicated codes yield 1, 2, 4 and 8-bit patterns.
- R8: A code or length write made in the middle of a pattern does not affect the rest of that pattern. It takes effect from the first bit of the next pattern.
- R9: After the enable is set, the first `line_ce` emits bit 7 of code byte 0. Disabling in the middle of a pattern and enabling again restarts the pattern from that bit.
- R10: Register map on `wr_addr`: 0 is code byte 0, 1 is code byte 1, 2 is the control byte with the length select in bits 7:6, and 3 is the enable in bit 0. All other bits of the control and enable bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_ce | input | 1 | One-cycle strobe, one line bit per pulse |
| tx_data | input | 1 | Normal transmit data bit, used while disabled |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| tx_bit | output | 1 | Line bit out, registered |

## Verification
A wrong bit position counter or a bad wrap point shows up on `tx_bit` within one period, at most 16 line bits. The stream drifts out of phase with the expected repeat, so comparing two full periods against the model exposes it. A shadow copy that is updated at the wrong time shows up as a truncated or mixed pattern on the first period after a mid-pattern write. An enable path that is wrong shows up at the very next `line_ce`, because the output then either passes `tx_data` or it does not.

// File: rtl/loopgen_pkg.sv
// Package: shared types and helpers for the loop code generator.
// Assumes the control byte is at least 2 bits wide so the length field fits.
package loopgen_pkg;

    // Length select encoding, written into the top two control bits.
    typedef enum logic [1:0] {
        LEN_FIVE  = 2'b00,
        LEN_SIX   = 2'b01,
        LEN_SEVEN = 2'b10,
        LEN_FULL  = 2'b11
    } len_sel_e;

    localparam int LEN_SEL_W = 2;

    // Period in bits for a length select; full_len is the width of the whole pattern.
    function automatic int unsigned period_of(len_sel_e sel, int unsigned full_len);
        int unsigned p;
        case (sel)
            LEN_FIVE:  p = 5;
            LEN_SIX:   p = 6;
            LEN_SEVEN: p = 7;
            default:   p = full_len;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/loopgen_regs.sv
// Module: loopgen_regs
// Holds the code bytes, the length select and the enable. Writes land on the
// clock edge where wr_en is high. Code bytes are packed MSB-first into one
// pattern word, so byte 0 occupies the top bits.
// Assumes ADDR_W is wide enough for NUM_CODES + 2 addresses.
module loopgen_regs
    import loopgen_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int NUM_CODES = 2,
    parameter int ADDR_W    = 2,
    localparam int PAT_W    = CODE_W * NUM_CODES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    output logic [PAT_W-1:0]  live_pattern,
    output len_sel_e          live_len,
    output logic              gen_en
);

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NUM_CODES);
    localparam logic [ADDR_W-1:0] ADDR_ENA  = ADDR_W'(NUM_CODES + 1);

    // One storage byte per code register, placed MSB-first in the pattern.
    for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_code
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(gi);
        logic [CODE_W-1:0] code_q;

        // Capture this code byte when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q <= '0;
            end else if (wr_en && (wr_addr == MY_ADDR)) begin
                code_q <= wr_data;
            end
        end

        assign live_pattern[PAT_W-1-gi*CODE_W -: CODE_W] = code_q;
    end

    // Capture the length select from the top bits of the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_len <= LEN_FIVE;
        end else if (wr_en && (wr_addr == ADDR_CTRL)) begin
            live_len <= len_sel_e'(wr_data[CODE_W-1 -: LEN_SEL_W]);
        end
    end

    // Capture the enable from bit 0 of the enable byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en <= 1'b0;
        end else if (wr_en && (wr_addr == ADDR_ENA)) begin
            gen_en <= wr_data[0];
        end
    end

endmodule

// File: rtl/loopgen_seq.sv
// Module: loopgen_seq
// Walks a bit position through the pattern, one step per line_ce. At position
// 0 it samples the live code and length into a shadow copy. The rest of the
// pattern is then taken from that copy, so writes only act at a pattern start.
// Assumes the period never exceeds PAT_W.
module loopgen_seq
    import loopgen_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int NUM_CODES = 2,
    localparam int PAT_W    = CODE_W * NUM_CODES,
    localparam int CNT_W    = $clog2(PAT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_ce,
    input  logic             gen_en,
    input  logic [PAT_W-1:0] live_pattern,
    input  len_sel_e         live_len,
    output logic [CNT_W-1:0] pos_q,
    output logic [PAT_W-1:0] shadow_pat,
    output len_sel_e         shadow_len,
    output logic             pat_bit
);

    logic             at_start;
    logic [PAT_W-1:0] cur_pat;
    len_sel_e         cur_len;
    logic [CNT_W:0]   cur_period;
    logic             at_last;

    // Select the live or the held pattern and find the bit for this position.
    always_comb begin
        at_start   = (pos_q == '0);
        cur_pat    = at_start ? live_pattern : shadow_pat;
        cur_len    = at_start ? live_len : shadow_len;
        cur_period = (CNT_W+1)'(period_of(cur_len, PAT_W));
        at_last    = ({1'b0, pos_q} == (cur_period - 1'b1));
        pat_bit    = cur_pat[CNT_W'(PAT_W-1) - pos_q];
    end

    // Advance the position and refresh the shadow copy at each pattern start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q      <= '0;
            shadow_pat <= '0;
            shadow_len <= LEN_FIVE;
        end else if (!gen_en) begin
            pos_q <= '0;
        end else if (line_ce) begin
            if (at_start) begin
                shadow_pat <= live_pattern;
                shadow_len <= live_len;
            end
            pos_q <= at_last ? '0 : pos_q + 1'b1;
        end
    end

endmodule

// File: rtl/loopgen_out.sv
// Module: loopgen_out
// Output register. On each line_ce it loads the pattern bit while the
// generator is enabled, and the normal data bit otherwise.
module loopgen_out (
    input  logic clk,
    input  logic rst_n,
    input  logic line_ce,
    input  logic gen_en,
    input  logic pat_bit,
    input  logic tx_data,
    output logic tx_bit
);

    // Register the selected line bit once per line strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit <= 1'b0;
        end else if (line_ce) begin
            tx_bit <= gen_en ? pat_bit : tx_data;
        end
    end

endmodule

// File: rtl/loopgen_top.sv
// Module: loopgen_top
// Repeating loop code generator: register file, pattern sequencer and line
// output register. Assumes a write and a line strobe may share a cycle; the
// sequencer then sees the old register values for that strobe.
module loopgen_top
    import loopgen_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int NUM_CODES = 2,
    parameter int ADDR_W    = 2,
    localparam int PAT_W    = CODE_W * NUM_CODES,
    localparam int CNT_W    = $clog2(PAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_ce,
    input  logic              tx_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    output logic              tx_bit
);

    logic [PAT_W-1:0] live_pattern;
    len_sel_e         live_len;
    logic             gen_en;
    logic [CNT_W-1:0] pos_q;
    logic [PAT_W-1:0] shadow_pat;
    len_sel_e         shadow_len;
    logic             pat_bit;

    loopgen_regs #(
        .CODE_W   (CODE_W),
        .NUM_CODES(NUM_CODES),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .live_pattern(live_pattern),
        .live_len    (live_len),
        .gen_en      (gen_en)
    );

    loopgen_seq #(
        .CODE_W   (CODE_W),
        .NUM_CODES(NUM_CODES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_ce     (line_ce),
        .gen_en      (gen_en),
        .live_pattern(live_pattern),
        .live_len    (live_len),
        .pos_q       (pos_q),
        .shadow_pat  (shadow_pat),
        .shadow_len  (shadow_len),
        .pat_bit     (pat_bit)
    );

    loopgen_out u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_ce(line_ce),
        .gen_en (gen_en),
        .pat_bit(pat_bit),
        .tx_data(tx_data),
        .tx_bit (tx_bit)
    );

endmodule

// File: rtl/loopgen_chk.sv
// Module: loopgen_chk
// Assertion checker for loopgen_top, attached by the bind below.
module loopgen_chk #(
    parameter int CNT_W = 4,
    parameter int PAT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_ce,
    input logic             tx_data,
    input logic             gen_en,
    input logic [CNT_W-1:0] pos_q,
    input logic [PAT_W-1:0] shadow_pat,
    input logic             tx_bit
);

    logic rst_seen_q;

    // Remember that the previous edge applied reset.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1: the cycle after reset the output is low and the position is cleared.
    always_ff @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            a_r1_reset_idle: assert (tx_bit == 1'b0 && pos_q == '0)
                else $error("a_r1_reset_idle");
        end
    end

    // R3: without a line strobe the output holds.
    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !line_ce |=> $stable(tx_bit));

    // R2: while disabled, a strobe passes the data bit through.
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (line_ce && !gen_en) |=> (tx_bit == $past(tx_data)));

    // R8: the held pattern changes only at a pattern start.
    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != '0) |=> $stable(shadow_pat));

    // R9: a strobe at a pattern start while enabled moves to the second bit.
    a_r9_start_step: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && line_ce && pos_q == '0) |=> (pos_q == CNT_W'(1)));

    // R4: inside a pattern the position steps by one or wraps to zero.
    a_r4_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && line_ce && pos_q != '0) |=>
            (pos_q == '0 || pos_q == $past(pos_q) + 1'b1));

endmodule

bind loopgen_top loopgen_chk #(
    .CNT_W(CNT_W),
    .PAT_W(PAT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_ce   (line_ce),
    .tx_data   (tx_data),
    .gen_en    (gen_en),
    .pos_q     (pos_q),
    .shadow_pat(shadow_pat),
    .tx_bit    (tx_bit)
);

// File: tb/loopgen_top_tb.sv
module loopgen_top_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_ce = 1'b0;
    logic       tx_data = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tx_bit;

    int checks = 0;
    int errors = 0;

    // Vector: {code byte 0, code byte 1, length select}
    localparam logic [17:0] VEC [8] = '{
        {8'h80, 8'h00, 2'b00},
        {8'hA8, 8'h00, 2'b01},
        {8'h92, 8'h00, 2'b01},
        {8'hE4, 8'h00, 2'b10},
        {8'hC3, 8'h5A, 2'b11},
        {8'h55, 8'h55, 2'b11},
        {8'hFF, 8'hFF, 2'b11},
        {8'hB7, 8'hB7, 2'b11}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    loopgen_top u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_ce(line_ce),
        .tx_data(tx_data),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .tx_bit (tx_bit)
    );

    function automatic int period_for(logic [1:0] sel);
        case (sel)
            2'b00:   return 5;
            2'b01:   return 6;
            2'b10:   return 7;
            default: return 16;
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: tx_bit actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One line strobe; tx_bit is sampled at the following falling edge.
    task automatic line_step(input logic d, output logic got);
        @(negedge clk);
        line_ce = 1'b1; tx_data = d;
        @(negedge clk);
        line_ce = 1'b0;
        got = tx_bit;
    endtask

    task automatic run_expect(input logic [15:0] pat, input int per, input int nbits,
                              input int start, input string req);
        logic got;
        for (int i = 0; i < nbits; i++) begin
            line_step(1'b0, got);
            check(got, pat[15 - ((start + i) % per)], req);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic got;
        string req;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_bit, 1'b0, "R1 reset output");

        // R2: pass-through while disabled
        line_step(1'b1, got); check(got, 1'b1, "R2 pass 1");
        line_step(1'b0, got); check(got, 1'b0, "R2 pass 0");
        line_step(1'b1, got); check(got, 1'b1, "R2 pass 1b");

        // R3: no strobe, output holds while data toggles
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); tx_data = ~tx_data;
            @(negedge clk); check(tx_bit, 1'b1, "R3 hold");
        end

        // Table walk: R4..R7 and R9
        for (int v = 0; v < 8; v++) begin
            write_reg(2'd3, 8'h00);
            write_reg(2'd0, VEC[v][17:10]);
            write_reg(2'd1, VEC[v][9:2]);
            write_reg(2'd2, {VEC[v][1:0], 6'b0});
            write_reg(2'd3, 8'h01);
            case (VEC[v][1:0])
                2'b00:   req = "R4 five-bit";
                2'b01:   req = "R5 six-bit";
                2'b10:   req = "R6 seven-bit";
                default: req = "R7 sixteen-bit";
            endcase
            run_expect(VEC[v][17:2], period_for(VEC[v][1:0]),
                       2 * period_for(VEC[v][1:0]), 0, req);
        end

        // R8: mid-pattern write waits for the pattern boundary
        write_reg(2'd3, 8'h00);
        write_reg(2'd0, 8'h80);
        write_reg(2'd1, 8'h00);
        write_reg(2'd2, 8'h00);
        write_reg(2'd3, 8'h01);
        run_expect(16'h8000, 5, 2, 0, "R8 old head");
        write_reg(2'd0, 8'h0F);
        write_reg(2'd1, 8'hF0);
        write_reg(2'd2, 8'hC0);
        run_expect(16'h8000, 5, 3, 2, "R8 old tail");
        run_expect(16'h0FF0, 16, 16, 0, "R8 new pattern");

        // R9: restart from the top after a mid-pattern disable
        run_expect(16'h0FF0, 16, 5, 0, "R9 run");
        write_reg(2'd3, 8'h00);
        line_step(1'b1, got); check(got, 1'b1, "R2 disable passes data");
        write_reg(2'd3, 8'h01);
        run_expect(16'h0FF0, 16, 6, 0, "R9 restart");

        // R10: ignored bits in the enable and control bytes
        write_reg(2'd3, 8'h02);
        line_step(1'b1, got); check(got, 1'b1, "R10 enable bit1 ignored");
        line_step(1'b0, got); check(got, 1'b0, "R10 enable bit1 ignored b");
        write_reg(2'd0, 8'h88);
        write_reg(2'd2, 8'h3F);
        write_reg(2'd3, 8'h01);
        run_expect(16'h8800, 5, 10, 0, "R10 control low bits ignored");

        // R1: reset while running
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(tx_bit, 1'b0, "R1 reset mid-run");
        line_step(1'b1, got); check(got, 1'b1, "R1 disabled after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule